// File: doc/BRIEF.md
# Host Bus Byte Register Interface

This block is an 8-bit I/O slave for an ISA-style stackable host bus. The host places a 15-bit I/O address on the bus, qualifies it with the address-enable line held low, and marks it with a pulse on the address-latch line. The block captures that address when the latch pulse falls. If the upper address bits match the card's base address, the block selects an eight-byte window.

Inside the window, five byte registers feed a downstream serial bridge and take data back from it. The registers are: transmit address, transmit data, control, instruction, and a receive-data byte that the bridge loads. A host write to the instruction register fires a one-cycle start pulse toward the bridge. A read of the control register reports the bridge's busy flag in its top bit. The shared data bus is driven only during a host read that selects this card; at all other times the pins are left at high impedance.

All bus lines are sampled on the bus clock, about 8.3 MHz. A basic transfer spans several wait states, which gives ample time for the edge detection on the latch and write strobes.

Top module: `hostbus_regfile`

## Requirements
- R1: After reset, every bridge-side output (transmit address, transmit data, control, instruction) is 0x00, the start pulse is low, the receive register reads back 0x00, and the data bus is not driven.
- R2: The address is captured at the first clock edge where the address-latch line is seen low after being high. Changes on the address lines after that edge do not change which register the cycle targets.
- R3: The card is selected only when the latched address bits above the 3-bit window offset equal those of BASE_ADDR. Offsets within the window are: 0 receive data, 1 transmit address, 2 transmit data, 3 control, 4 instruction. Addresses outside the window are neither read nor written.
- R4: A cycle whose address-enable line is high at address latch or at the strobe neither writes any register nor drives the data bus.
- R5: A write is taken at the first clock edge where the write strobe is seen low after being high, using the data on the bus at that edge. The new value appears on the matching bridge output after that edge.
- R6: While the read strobe is low, address-enable is low and the card is selected, the data bus carries the addressed register value in the same cycle. Offsets 1, 2 and 4 return the last written byte; offset 0 returns the receive register.
- R7: The data bus is at high impedance whenever the read strobe is high.
- R8: Each write to offset 4 raises the start output for exactly one clock cycle, beginning right after the write edge. No other write raises it.
- R9: Offsets 5, 6 and 7 read as 0x00, and writes to them change no register.
- R10: The receive register loads the receive-data input on every clock edge with the receive-valid input high. A host write to offset 0 leaves it unchanged.
- R11: A read of offset 3 returns the live busy input in bit 7 and the stored control bits 6..0 below it. The control output itself carries all 8 written bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 15 | Host I/O address lines |
| bus_data | inout | 8 | Bidirectional host data bus |
| aen | input | 1 | Address enable, low for a valid I/O cycle |
| ale | input | 1 | Address latch pulse, address taken on its falling edge |
| iow_n | input | 1 | Active-low I/O write strobe |
| ior_n | input | 1 | Active-low I/O read strobe |
| tx_addr_o | output | 8 | Transmit address byte to the bridge |
| tx_data_o | output | 8 | Transmit data byte to the bridge |
| ctrl_o | output | 8 | Control byte to the bridge |
| instr_o | output | 8 | Instruction byte to the bridge |
| start_o | output | 1 | One-cycle start pulse after an instruction write |
| bridge_busy_i | input | 1 | Bridge transfer in progress |
| rx_valid_i | input | 1 | Load strobe for the receive byte |
| rx_data_i | input | 8 | Receive byte from the bridge |

## Verification
The latched address is usable one edge after the latch line is seen low. A write lands on the bridge outputs, and any start pulse rises, just after the first edge that sees the write strobe low. A read drives the bus combinationally in the same cycle that the read strobe is low. The bench drives every input at a falling clock edge and samples one falling edge after the rising edge that acts on it. It samples the start output at two successive falling edges, so a single-cycle pulse is proved both to rise and to end. An undriven bus is observed through bench pull-ups as 0xFF.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
  localparam int OFS_RXD = 0;
  localparam int OFS_TXA = 1;
  localparam int OFS_TXD = 2;
  localparam int OFS_CTL = 3;
  localparam int OFS_INS = 4;
  localparam int NUM_REGS = 5;
endpackage

// File: rtl/hbr_rst_sync.sv
module hbr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/hbr_addr_decode.sv
module hbr_addr_decode #(
  parameter int ADDR_W    = 15,
  parameter int WIN_W     = 3,
  parameter int BASE_ADDR = 'h300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic              aen,
  input  logic [ADDR_W-1:0] addr,
  output logic              sel_o,
  output logic [WIN_W-1:0]  ofs_o
);
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);

  logic              ale_q;
  logic              vld_q, vld_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              ale_fall;

  assign ale_fall = ale_q & ~ale;

  always_comb begin
    vld_d  = vld_q;
    addr_d = addr_q;
    if (ale_fall) begin
      vld_d  = ~aen;
      addr_d = addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_q  <= 1'b0;
      vld_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      ale_q <= ale;
      if (ale_fall) begin
        vld_q  <= vld_d;
        addr_q <= addr_d;
      end
    end
  end

  assign sel_o = vld_q && (addr_q[ADDR_W-1:WIN_W] == BASE_V[ADDR_W-1:WIN_W]);
  assign ofs_o = addr_q[WIN_W-1:0];
endmodule

// File: rtl/hbr_reg_bank.sv
module hbr_reg_bank
  import hbr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WIN_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [WIN_W-1:0]  ofs,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              busy,
  output logic [DATA_W-1:0] tx_addr,
  output logic [DATA_W-1:0] tx_data,
  output logic [DATA_W-1:0] ctrl,
  output logic [DATA_W-1:0] instr,
  output logic [DATA_W-1:0] rx_q,
  output logic [DATA_W-1:0] rdata,
  output logic              start
);
  logic [NUM_REGS-1:0] hit;
  logic [NUM_REGS-1:0] wen;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_REGS; gi++) begin : g_hit
      assign hit[gi] = (ofs == WIN_W'(gi));
      assign wen[gi] = wr_stb & hit[gi];
    end
  endgenerate

  logic [DATA_W-1:0] txa_d, txd_d, ctl_d, ins_d, rx_d;
  logic              start_d;

  always_comb begin
    txa_d   = wen[OFS_TXA] ? wdata : tx_addr;
    txd_d   = wen[OFS_TXD] ? wdata : tx_data;
    ctl_d   = wen[OFS_CTL] ? wdata : ctrl;
    ins_d   = wen[OFS_INS] ? wdata : instr;
    rx_d    = rx_valid ? rx_data : rx_q;
    start_d = wen[OFS_INS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_addr <= '0;
      tx_data <= '0;
      ctrl    <= '0;
      instr   <= '0;
      rx_q    <= '0;
      start   <= 1'b0;
    end else begin
      tx_addr <= txa_d;
      tx_data <= txd_d;
      ctrl    <= ctl_d;
      instr   <= ins_d;
      rx_q    <= rx_d;
      start   <= start_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit[OFS_RXD]) rdata = rx_q;
    if (hit[OFS_TXA]) rdata = tx_addr;
    if (hit[OFS_TXD]) rdata = tx_data;
    if (hit[OFS_CTL]) rdata = {busy, ctrl[DATA_W-2:0]};
    if (hit[OFS_INS]) rdata = instr;
  end
endmodule

// File: rtl/hostbus_regfile.sv
module hostbus_regfile #(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int WIN_W     = 3,
  parameter int BASE_ADDR = 'h300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  inout  wire  [DATA_W-1:0] bus_data,
  input  logic              aen,
  input  logic              ale,
  input  logic              iow_n,
  input  logic              ior_n,
  output logic [DATA_W-1:0] tx_addr_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] instr_o,
  output logic              start_o,
  input  logic              bridge_busy_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i
);
  logic              rst_s_n;
  logic              sel;
  logic [WIN_W-1:0]  ofs;
  logic              iow_q;
  logic              wr_stb;
  logic              drv_en;
  logic [DATA_W-1:0] rdata;
  logic [DATA_W-1:0] rx_q;

  hbr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  hbr_addr_decode #(
    .ADDR_W    (ADDR_W),
    .WIN_W     (WIN_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_dec (
    .clk   (clk),
    .rst_n (rst_s_n),
    .ale   (ale),
    .aen   (aen),
    .addr  (bus_addr),
    .sel_o (sel),
    .ofs_o (ofs)
  );

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) iow_q <= 1'b1;
    else          iow_q <= iow_n;
  end

  assign wr_stb = iow_q & ~iow_n & ~aen & sel;
  assign drv_en = sel & ~aen & ~ior_n;

  hbr_reg_bank #(
    .DATA_W (DATA_W),
    .WIN_W  (WIN_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .wr_stb   (wr_stb),
    .ofs      (ofs),
    .wdata    (bus_data),
    .rx_valid (rx_valid_i),
    .rx_data  (rx_data_i),
    .busy     (bridge_busy_i),
    .tx_addr  (tx_addr_o),
    .tx_data  (tx_data_o),
    .ctrl     (ctrl_o),
    .instr    (instr_o),
    .rx_q     (rx_q),
    .rdata    (rdata),
    .start    (start_o)
  );

  assign bus_data = drv_en ? rdata : {DATA_W{1'bz}};
endmodule

// File: rtl/hostbus_regfile_chk.sv
module hostbus_regfile_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              aen,
  input logic              ior_n,
  input logic              iow_n,
  input logic              drv_en,
  input logic              start_o,
  input logic              rx_valid_i,
  input logic [DATA_W-1:0] tx_addr_o,
  input logic [DATA_W-1:0] instr_o,
  input logic [DATA_W-1:0] rx_q
);
  p_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ior_n |-> !drv_en);

  p_aen_nodrive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    aen |-> !drv_en);

  p_start_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

  p_start_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(!iow_n && !aen));

  p_txa_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (iow_n || aen) |=> $stable(tx_addr_o));

  p_ins_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (iow_n || aen) |=> $stable(instr_o));

  p_rx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid_i |=> $stable(rx_q));
endmodule

bind hostbus_regfile hostbus_regfile_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .aen        (aen),
  .ior_n      (ior_n),
  .iow_n      (iow_n),
  .drv_en     (drv_en),
  .start_o    (start_o),
  .rx_valid_i (rx_valid_i),
  .tx_addr_o  (tx_addr_o),
  .instr_o    (instr_o),
  .rx_q       (rx_q)
);

// File: tb/hostbus_regfile_test.sv
`timescale 1ns/1ps
module hostbus_regfile_test;
  localparam int BASE = 'h300;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [14:0] bus_addr;
  wire  [7:0]  bus_data;
  logic        aen, ale, iow_n, ior_n;
  logic [7:0]  tx_addr_o, tx_data_o, ctrl_o, instr_o;
  logic        start_o;
  logic        busy, rx_valid;
  logic [7:0]  rx_data;
  logic [7:0]  host_dout;
  logic        host_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [7:0] m_reg [0:4];

  always #10 clk = ~clk;

  assign bus_data = host_oe ? host_dout : 8'bz;
  for (genvar gi = 0; gi < 8; gi++) begin : g_pu
    pullup pu (bus_data[gi]);
  end

  hostbus_regfile uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
    .aen(aen), .ale(ale), .iow_n(iow_n), .ior_n(ior_n),
    .tx_addr_o(tx_addr_o), .tx_data_o(tx_data_o), .ctrl_o(ctrl_o),
    .instr_o(instr_o), .start_o(start_o), .bridge_busy_i(busy),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [2:0] o, input logic b);
    case (o)
      3'd0: return m_reg[0];
      3'd1: return m_reg[1];
      3'd2: return m_reg[2];
      3'd3: return {b, m_reg[3][6:0]};
      3'd4: return m_reg[4];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic in_win(input logic [14:0] a);
    return a[14:3] == 12'(BASE >> 3);
  endfunction

  task automatic cycle(input logic wr, input logic [14:0] a, input logic [7:0] d,
                       input logic aen_v, input logic scramble,
                       output logic [7:0] rd, output logic s1, output logic s2);
    @(negedge clk); bus_addr = a; aen = aen_v; ale = 1'b1;
    @(negedge clk); ale = 1'b0;
    @(negedge clk);
    if (scramble) bus_addr = ~a;
    if (wr) begin host_dout = d; host_oe = 1'b1; iow_n = 1'b0; end
    else ior_n = 1'b0;
    @(negedge clk); s1 = start_o; rd = bus_data;
    @(negedge clk); s2 = start_o;
    repeat (2) @(negedge clk);
    iow_n = 1'b1; ior_n = 1'b1; host_oe = 1'b0; aen = 1'b1;
    @(negedge clk);
    if (wr && !aen_v && in_win(a) && a[2:0] >= 3'd1 && a[2:0] <= 3'd4) m_reg[a[2:0]] = d;
  endtask

  task automatic rx_load(input logic [7:0] d);
    @(negedge clk); rx_valid = 1'b1; rx_data = d;
    @(negedge clk); rx_valid = 1'b0;
    m_reg[0] = d;
  endtask

  task automatic outs_check(input string req);
    chk(req, tx_addr_o, m_reg[1]);
    chk(req, tx_data_o, m_reg[2]);
    chk(req, ctrl_o,    m_reg[3]);
    chk(req, instr_o,   m_reg[4]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic s1, s2;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 5; i++) m_reg[i] = 8'h00;
    rst_n = 1'b0; bus_addr = '0; aen = 1'b1; ale = 1'b0; iow_n = 1'b1; ior_n = 1'b1;
    busy = 1'b0; rx_valid = 1'b0; rx_data = '0; host_dout = '0; host_oe = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    outs_check("R1 reset outputs");
    chk("R1 start idle", {7'd0, start_o}, 8'h00);
    chk("R1 bus undriven", bus_data, 8'hFF);
    cycle(1'b0, 15'(BASE + 1), 8'h00, 1'b0, 1'b0, rd, s1, s2);
    chk("R1 reg reads zero", rd, 8'h00);
    cycle(1'b0, 15'(BASE + 0), 8'h00, 1'b0, 1'b0, rd, s1, s2);
    chk("R1 rx reads zero", rd, 8'h00);

    // R5, R6: write then read back
    cycle(1'b1, 15'(BASE + 1), 8'hA5, 1'b0, 1'b0, rd, s1, s2);
    chk("R5 tx_addr", tx_addr_o, 8'hA5);
    chk("R8 no start on txa write", {7'd0, s1}, 8'h00);
    cycle(1'b0, 15'(BASE + 1), 8'h00, 1'b0, 1'b0, rd, s1, s2);
    chk("R6 read txa", rd, 8'hA5);

    // R11: control busy bit
    cycle(1'b1, 15'(BASE + 3), 8'h7E, 1'b0, 1'b0, rd, s1, s2);
    chk("R11 ctrl output", ctrl_o, 8'h7E);
    busy = 1'b1;
    cycle(1'b0, 15'(BASE + 3), 8'h00, 1'b0, 1'b0, rd, s1, s2);
    chk("R11 ctrl busy read", rd, 8'hFE);
    busy = 1'b0;
    cycle(1'b0, 15'(BASE + 3), 8'h00, 1'b0, 1'b0, rd, s1, s2);
    chk("R11 ctrl idle read", rd, 8'h7E);

    // R8: start pulse
    cycle(1'b1, 15'(BASE + 4), 8'h5A, 1'b0, 1'b0, rd, s1, s2);
    chk("R8 start high", {7'd0, s1}, 8'h01);
    chk("R8 start one cycle", {7'd0, s2}, 8'h00);
    chk("R5 instr", instr_o, 8'h5A);

    // R10: receive register
    cycle(1'b1, 15'(BASE + 0), 8'h99, 1'b0, 1'b0, rd, s1, s2);
    cycle(1'b0, 15'(BASE + 0), 8'h00, 1'b0, 1'b0, rd, s1, s2);
    chk("R10 host write ignored", rd, 8'h00);
    rx_load(8'h42);
    cycle(1'b0, 15'(BASE + 0), 8'h00, 1'b0, 1'b0, rd, s1, s2);
    chk("R10 rx load", rd, 8'h42);

    // R9: unused offsets
    cycle(1'b1, 15'(BASE + 5), 8'h11, 1'b0, 1'b0, rd, s1, s2);
    outs_check("R9 write ignored");
    cycle(1'b0, 15'(BASE + 5), 8'h00, 1'b0, 1'b0, rd, s1, s2);
    chk("R9 unused reads zero", rd, 8'h00);

    // R3: outside window
    cycle(1'b1, 15'(BASE + 8 + 1), 8'h00, 1'b0, 1'b0, rd, s1, s2);
    outs_check("R3 outside write ignored");
    cycle(1'b0, 15'(BASE + 8 + 1), 8'h00, 1'b0, 1'b0, rd, s1, s2);
    chk("R3 outside not driven", rd, 8'hFF);

    // R4: aen high
    cycle(1'b1, 15'(BASE + 1), 8'h00, 1'b1, 1'b0, rd, s1, s2);
    outs_check("R4 aen write ignored");
    cycle(1'b0, 15'(BASE + 1), 8'h00, 1'b1, 1'b0, rd, s1, s2);
    chk("R4 aen not driven", rd, 8'hFF);

    // R2: address changes after latch
    cycle(1'b1, 15'(BASE + 2), 8'h3C, 1'b0, 1'b1, rd, s1, s2);
    chk("R2 latched target", tx_data_o, 8'h3C);
    cycle(1'b0, 15'(BASE + 2), 8'h00, 1'b0, 1'b1, rd, s1, s2);
    chk("R2 latched read", rd, 8'h3C);

    // R7: bus idle
    chk("R7 idle bus", bus_data, 8'hFF);

    // constrained random
    for (int k = 0; k < 400; k++) begin
      logic        wr, av, inw;
      logic [14:0] a;
      logic [7:0]  d, ex;
      wr  = $urandom_range(0, 1) == 1;
      av  = $urandom_range(0, 9) == 0;
      inw = $urandom_range(0, 7) != 0;
      d   = 8'($urandom);
      busy = $urandom_range(0, 1) == 1;
      if (inw) a = 15'(BASE) | 15'($urandom_range(0, 7));
      else begin
        a = 15'($urandom);
        if (in_win(a)) a = a ^ 15'h4000;
      end
      if ($urandom_range(0, 5) == 0) rx_load(8'($urandom));
      cycle(wr, a, d, av, 1'($urandom_range(0, 1)), rd, s1, s2);
      if (wr) begin
        outs_check("R5 random write");
        chk("R8 random start",
            {7'd0, s1}, {7'd0, (!av && in_win(a) && a[2:0] == 3'd4)});
      end else begin
        ex = (!av && in_win(a)) ? exp_read(a[2:0], busy) : 8'hFF;
        chk("R6 random read", rd, ex);
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule